// File: doc/BRIEF.md
# Multi-Mode Timer Channel

A 16-bit counter channel that serves three uses from one counter. In timer mode it counts down on a prescaler tick from a programmed reload value. In event mode it counts down on edges of an external input, or on underflow pulses from a neighbouring channel. In measurement mode it counts up on the tick and captures the count between edges of an external signal. One interrupt request carries the cause that belongs to the active mode.

The channel is set up through a small register write port. Address 0 holds the reload value. Address 1 is the control register:

- Bits [1:0] select the mode: 00 timer, 01 event, 10 period measurement, 11 width measurement.
- Bit 2 selects the event source: 0 is the external input, 1 is the cascade input.
- Bits [4:3] select the active edge: 00 rising, 01 falling, 1x both.
- Bit 5 is the run bit.

Every channel is self-contained, so several can sit side by side with one feeding another through the cascade path. The external input passes through a two-flop synchronizer and an edge detector. A detected edge therefore acts on the counter three clock edges after the input changes.

Top module: `mmtimer_ch`

## Requirements
- R1: After reset, irq, uflow_out, ovf_flag, cnt_out and cap_out are all 0.
- R2: In timer mode (mode 00), the counter behaves as follows:
  - A control write with bit 5 set loads the reload value.
  - The counter then decrements once per clock where tick is 1, and holds where tick is 0.
  - On a tick while it is 0, it reloads, so underflows repeat every reload+1 ticks.
- R3: Each underflow gives a one-cycle pulse on uflow_out in the same cycle as a pulse on irq.
- R4: A control write with bit 5 clear leaves the counter at its current value, and the counter then holds regardless of tick or edges.
- R5: In event mode (mode 01) with bit 2 clear, the counter decrements once per external edge of the selected polarity (bits [4:3]: 00 rising, 01 falling, 1x both). Tick has no effect in this mode.
- R6: In event mode with bit 2 set, the counter decrements once per clock where cascade_in is 1.
- R7: In period mode (mode 10), the counter counts up on tick. On each edge of the selected polarity, it copies its value to cap_out, clears to 0 and pulses irq, so a period of N clocks captures N-1.
- R8: In width mode (mode 11), both edges capture and clear whatever the polarity bits hold, so a high phase of N clocks captures N-1.
- R9: In either measurement mode, a tick at count 0xFFFF does three things: the counter wraps to 0, ovf_flag sets and irq pulses. ovf_flag stays set until the next control write.
- R10: A write to the reload register while the channel runs does not change the current count. It takes effect at the next underflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | Register select: 0 reload, 1 control |
| wr_data | input | 16 | Write data |
| tick | input | 1 | Count-enable tick from the prescaler |
| ext_in | input | 1 | External pulse input (asynchronous) |
| cascade_in | input | 1 | Underflow pulse from a neighbouring channel |
| irq | output | 1 | One-cycle interrupt request |
| uflow_out | output | 1 | One-cycle underflow pulse for cascading |
| cnt_out | output | 16 | Current counter value |
| cap_out | output | 16 | Last captured measurement |
| ovf_flag | output | 1 | Sticky measurement overflow status |

## Verification
The hardest case to reach is the measurement overflow. It needs 65,536 ticks without an active edge. The bench reaches it by starting period mode with the external input held low and tick held high, then running past the wrap. It then checks three things: the sticky flag is set, the counter has restarted from zero, and the next control write clears the flag.

The edge-driven modes are also hard to check, because of the three-clock delay through the synchronizer. The bench therefore shapes pulses with known high and low lengths. It compares counts and captures only after the pipeline has settled.

// File: rtl/mmtimer_ch.sv
module mmtimer_ch #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic         wr_addr,
  input  logic [W-1:0] wr_data,
  input  logic         tick,
  input  logic         ext_in,
  input  logic         cascade_in,
  output logic         irq,
  output logic         uflow_out,
  output logic [W-1:0] cnt_out,
  output logic [W-1:0] cap_out,
  output logic         ovf_flag
);
  localparam logic A_RELOAD = 1'b0;
  localparam logic A_CTRL   = 1'b1;
  localparam logic [1:0] M_TIMER = 2'b00;
  localparam logic [1:0] M_WIDTH = 2'b11;

  logic [W-1:0] reload_q, cnt_q, cap_q;
  logic [1:0]   mode_q, esel_q;
  logic         src_q, run_q, ovf_q, irq_q, uf_q;
  logic [2:0]   sync_q;

  wire rise     = sync_q[1] & ~sync_q[2];
  wire fall     = ~sync_q[1] & sync_q[2];
  wire pol_edge = esel_q[1] ? (rise | fall) : (esel_q[0] ? fall : rise);
  wire meas     = mode_q[1];
  wire m_edge   = (mode_q == M_WIDTH) ? (rise | fall) : pol_edge;
  wire dn_en    = (mode_q == M_TIMER) ? tick : (src_q ? cascade_in : pol_edge);
  wire ctrl_wr  = wr_en && (wr_addr == A_CTRL);
  wire at_zero  = (cnt_q == '0);
  wire at_max   = &cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload_q <= '0;
      cnt_q    <= '0;
      cap_q    <= '0;
      mode_q   <= M_TIMER;
      esel_q   <= 2'b00;
      src_q    <= 1'b0;
      run_q    <= 1'b0;
      ovf_q    <= 1'b0;
      irq_q    <= 1'b0;
      uf_q     <= 1'b0;
      sync_q   <= '0;
    end else begin
      irq_q  <= 1'b0;
      uf_q   <= 1'b0;
      sync_q <= {sync_q[1:0], ext_in};
      if (wr_en && wr_addr == A_RELOAD) reload_q <= wr_data;
      if (ctrl_wr) begin
        mode_q <= wr_data[1:0];
        src_q  <= wr_data[2];
        esel_q <= wr_data[4:3];
        run_q  <= wr_data[5];
        ovf_q  <= 1'b0;
        if (wr_data[5]) cnt_q <= wr_data[1] ? '0 : reload_q;
      end else if (run_q) begin
        if (!meas) begin
          if (dn_en) begin
            if (at_zero) begin
              cnt_q <= reload_q;
              uf_q  <= 1'b1;
              irq_q <= 1'b1;
            end else begin
              cnt_q <= cnt_q - 1'b1;
            end
          end
        end else if (m_edge) begin
          cap_q <= cnt_q;
          cnt_q <= '0;
          irq_q <= 1'b1;
        end else if (tick) begin
          if (at_max) begin
            cnt_q <= '0;
            ovf_q <= 1'b1;
            irq_q <= 1'b1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
      end
    end
  end

  assign irq       = irq_q;
  assign uflow_out = uf_q;
  assign cnt_out   = cnt_q;
  assign cap_out   = cap_q;
  assign ovf_flag  = ovf_q;
endmodule

// File: rtl/mmtimer_ch_chk.sv
module mmtimer_ch_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         wr_en,
  input logic         wr_addr,
  input logic         tick,
  input logic         run_q,
  input logic [1:0]   mode_q,
  input logic         irq,
  input logic         uflow_out,
  input logic [W-1:0] cnt_out,
  input logic         ovf_flag
);
  a_r3_uflow_with_irq: assert property (@(posedge clk) disable iff (!rst_n)
    uflow_out |-> irq);

  a_r3_uflow_only_down: assert property (@(posedge clk) disable iff (!rst_n)
    uflow_out |-> !mode_q[1]);

  a_r4_hold_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !wr_en) |=> $stable(cnt_out));

  a_r2_tick_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 2'b00 && !tick && !wr_en) |=> $stable(cnt_out));

  a_r9_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !(wr_en && wr_addr)) |=> ovf_flag);

  a_r9_ovf_in_measure: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_flag) |-> (mode_q[1] && $past(irq == 1'b0 || 1'b1) && irq));
endmodule

bind mmtimer_ch mmtimer_ch_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .tick(tick),
  .run_q(run_q), .mode_q(mode_q), .irq(irq), .uflow_out(uflow_out),
  .cnt_out(cnt_out), .ovf_flag(ovf_flag)
);

// File: tb/sim_mmtimer_ch.sv
module sim_mmtimer_ch;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16;
  localparam int NV = 5;
  localparam logic [15:0] RELOADS [NV] = '{16'd0, 16'd1, 16'd5, 16'd20, 16'd37};

  logic clk = 0, rst_n = 0, wr_en = 0, wr_addr = 0, tick = 0, ext_in = 0, cascade_in = 0;
  logic [W-1:0] wr_data = '0;
  logic irq, uflow_out, ovf_flag;
  logic [W-1:0] cnt_out, cap_out;
  int checks = 0, fails = 0, irq_seen = 0;
  bit done = 0;

  mmtimer_ch #(.W(W)) u0 (.*);

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(negedge clk) if (irq) irq_seen++;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [W-1:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  function automatic logic [W-1:0] ctl(input logic [1:0] m, input logic s,
                                       input logic [1:0] e, input logic r);
    return W'({r, e, s, m});
  endfunction

  task automatic pulse(input int hi, input int lo);
    ext_in = 1; repeat (hi) @(negedge clk);
    ext_in = 0; repeat (lo) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    int first, second;
    logic [W-1:0] held;
    repeat (3) @(negedge clk);
    check("R1 irq", irq, 0); check("R1 uflow", uflow_out, 0);
    check("R1 ovf", ovf_flag, 0); check("R1 cnt", cnt_out, 0); check("R1 cap", cap_out, 0);
    rst_n = 1;

    // R2 R3 underflow period table
    for (int v = 0; v < NV; v++) begin
      wr(1'b1, ctl(2'b00, 0, 2'b00, 0));
      wr(1'b0, RELOADS[v]);
      tick = 1;
      wr(1'b1, ctl(2'b00, 0, 2'b00, 1));
      first = -1; second = -1;
      for (int i = 0; i < 200 && second < 0; i++) begin
        if (uflow_out) begin
          check("R3 irq with uflow", irq, 1);
          if (first < 0) first = i; else second = i;
        end
        @(negedge clk);
      end
      check("R2 period", second - first, RELOADS[v] + 1);
      tick = 0;
    end

    // R2 tick gate
    wr(1'b1, ctl(2'b00, 0, 2'b00, 0));
    wr(1'b0, 16'd20);
    wr(1'b1, ctl(2'b00, 0, 2'b00, 1));
    repeat (5) @(negedge clk);
    check("R2 tick low holds", cnt_out, 20);
    tick = 1; repeat (4) @(negedge clk); tick = 0;
    check("R2 tick counts", cnt_out, 16);

    // R4 stop holds
    wr(1'b1, ctl(2'b00, 0, 2'b00, 0));
    held = cnt_out; tick = 1; cascade_in = 1;
    repeat (6) @(negedge clk);
    check("R4 stopped hold", cnt_out, held);
    tick = 0; cascade_in = 0;

    // R10 reload write while running
    wr(1'b0, 16'd50);
    wr(1'b1, ctl(2'b00, 0, 2'b00, 1));
    wr(1'b0, 16'd7);
    check("R10 count unchanged", cnt_out, 50);
    tick = 1; repeat (51) @(negedge clk); tick = 0;
    check("R10 new reload at underflow", cnt_out, 7);

    // R5 event rising, falling, both; tick held high
    tick = 1;
    wr(1'b1, ctl(2'b00, 0, 2'b00, 0));
    wr(1'b0, 16'd10);
    wr(1'b1, ctl(2'b01, 0, 2'b00, 1));
    pulse(3, 3); pulse(3, 3); repeat (4) @(negedge clk);
    check("R5 rising", cnt_out, 8);
    wr(1'b1, ctl(2'b01, 0, 2'b01, 1));
    pulse(3, 3); repeat (4) @(negedge clk);
    check("R5 falling", cnt_out, 9);
    wr(1'b1, ctl(2'b01, 0, 2'b10, 1));
    pulse(3, 3); pulse(3, 3); pulse(3, 3); repeat (4) @(negedge clk);
    check("R5 both", cnt_out, 4);

    // R6 cascade source
    wr(1'b1, ctl(2'b01, 1, 2'b00, 1));
    @(negedge clk); cascade_in = 1; repeat (3) @(negedge clk); cascade_in = 0;
    check("R6 cascade", cnt_out, 7);
    pulse(3, 3); repeat (4) @(negedge clk);
    check("R6 ext ignored", cnt_out, 7);

    // R7 period capture
    wr(1'b1, ctl(2'b10, 0, 2'b00, 1));
    irq_seen = 0;
    pulse(5, 5); pulse(5, 5); pulse(5, 5);
    check("R7 capture", cap_out, 9);
    check("R7 irq count", irq_seen, 3);

    // R8 width capture, polarity bits ignored
    wr(1'b1, ctl(2'b11, 0, 2'b01, 1));
    irq_seen = 0;
    pulse(4, 6);
    check("R8 width", cap_out, 3);
    check("R8 irq count", irq_seen, 2);

    // R9 measurement overflow
    wr(1'b1, ctl(2'b10, 0, 2'b00, 1));
    irq_seen = 0;
    repeat (65540) @(negedge clk);
    check("R9 ovf set", ovf_flag, 1);
    check("R9 wrapped", cnt_out < 16, 1);
    check("R9 irq", irq_seen, 1);
    wr(1'b1, ctl(2'b10, 0, 2'b00, 1));
    check("R9 ovf cleared", ovf_flag, 0);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule